// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit

This block is the compare side of a timer with eight channels. Each channel holds a 16-bit compare value. When the channel is enabled, a hardware comparator checks that value against a shared counter on every count tick. A match sets the channel's event flag, which can raise an interrupt. The match also changes the state of the timer's output pins.

Channels 0 to 6 each control only their own pin, following a 2-bit action code. Channel 7 writes a group of pins chosen by a mask, using values from a data field. On any pin that both act on in the same cycle, channel 7 wins. Software can also force a channel's pin action at once. A forced action never sets a flag.

The block is programmed through a simple single-cycle register port. Writes take effect at the clock edge and reads are combinational. The counter and its tick come from outside.

Top module: `oc_unit`

## Requirements
- R1: After reset, all registers, the pin state `pins`, the flags and `irq` are 0.
- R2: A match needs three things at a rising clock edge: `tick` is 1, the channel's enable bit is 1, and `cnt` equals its compare value. At that edge the match sets the channel's flag and applies its pin action. The flags read at address 12 and the enable bits sit at address 8. A channel with enable 0 never matches. It is also unaffected by a force.
- R3: With `tick` low, no match happens, even when `cnt` equals a compare value. A counter held at one value therefore produces only one match.
- R4: For channels 0 to 6 the action code works as follows: 00 leaves the pin alone, 01 toggles it, 10 drives it low and 11 drives it high. Channel k (k<4) uses bits [2k+1:2k] of address 9. Channel k (k>=4) uses bits [2(k-4)+1:2(k-4)] of address 10.
- R5: A channel-7 action sets each pin whose mask bit is 1 to the matching data bit. The mask is bits [7:0] of address 11 and the data is bits [15:8]. Pins whose mask bit is 0 keep their value.
- R6: When channel 7 and a channel 0 to 6 act in the same cycle on the same pin, the channel-7 value is the one that takes effect on that pin.
- R7: Writing 1 to a bit at address 12 clears that flag. Writing 0 leaves it unchanged. If a match and a clear reach the same flag in the same cycle, the flag ends up set.
- R8: `irq[i]` is 1 exactly when flag i is 1 and its enable bit at address 13 is 1.
- R9: Writing 1 to bit i at address 14 applies channel i's pin action at that edge and does not set its flag. When a force and a match hit the same channel in the same cycle, the action is applied once and no flag is set.
- R10: Address 14 always reads 0.
- R11: Addresses 0 to 7 (compare values), 8, 9, 10, 11 and 13 read back what was written. Address 15 reads the pin state in its low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Counter advance strobe; a match is evaluated only when it is 1 |
| cnt | input | 16 | Shared counter value |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pins | output | 8 | Output pin state |
| irq | output | 8 | Per-channel interrupt requests |

## Verification
The assertions check a few rules on every cycle:
- no flag rises without a tick;
- a disabled channel never raises a flag;
- the pins stay still when there is neither a tick nor a force;
- after any channel-7 action, the masked pins carry the data bits;
- the force address reads as zero.

Some behaviours only the bench scenarios can show. These are the exact outcome of each action code, toggling from a known pin history, set-over-clear on a flag, and a force coinciding with a match. The priority case, where channel 1 drives a pin high while channel 7 drives it low in the same cycle, also needs a scenario.

// File: rtl/oc_unit.sv
module oc_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [7:0]    pins,
  output logic [7:0]    irq
);
  localparam int NCH = 8;

  logic [CW-1:0] cmp [NCH];
  logic [7:0]    en, ien, flg, msk7, dat7, match, frc, hit, pins_nx;
  logic [13:0]   act;

  assign frc = (wr_en && addr == 4'd14) ? (wdata[7:0] & en) : 8'h00;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_cmp
      assign match[g] = tick & en[g] & (cnt == cmp[g]);
      always_ff @(posedge clk) begin
        if (!rst_n) cmp[g] <= '0;
        else if (wr_en && addr == 4'(g)) cmp[g] <= wdata;
      end
    end
  endgenerate

  assign hit = match | frc;

  always_comb begin
    pins_nx = pins;
    for (int i = 0; i < NCH - 1; i++) begin
      if (hit[i]) begin
        case (act[2*i +: 2])
          2'b01:   pins_nx[i] = ~pins[i];
          2'b10:   pins_nx[i] = 1'b0;
          2'b11:   pins_nx[i] = 1'b1;
          default: pins_nx[i] = pins[i];
        endcase
      end
    end
    if (hit[7]) pins_nx = (pins_nx & ~msk7) | (dat7 & msk7);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; ien <= '0; flg <= '0; msk7 <= '0; dat7 <= '0; act <= '0; pins <= '0;
    end else begin
      pins <= pins_nx;
      flg  <= (flg & ~((wr_en && addr == 4'd12) ? wdata[7:0] : 8'h00)) | (match & ~frc);
      if (wr_en) begin
        case (addr)
          4'd8:  en  <= wdata[7:0];
          4'd9:  act[7:0] <= wdata[7:0];
          4'd10: act[13:8] <= wdata[5:0];
          4'd11: begin msk7 <= wdata[7:0]; dat7 <= wdata[15:8]; end
          4'd13: ien <= wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  assign irq = flg & ien;

  always_comb begin
    case (addr)
      4'd8:    rdata = CW'(en);
      4'd9:    rdata = CW'(act[7:0]);
      4'd10:   rdata = CW'(act[13:8]);
      4'd11:   rdata = CW'({dat7, msk7});
      4'd12:   rdata = CW'(flg);
      4'd13:   rdata = CW'(ien);
      4'd14:   rdata = '0;
      4'd15:   rdata = CW'(pins);
      default: rdata = cmp[addr[2:0]];
    endcase
  end

  a_r3_no_flag_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((flg & ~$past(flg)) == 8'h00));

  a_r2_disabled_never_flags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg & ~$past(flg) & ~$past(en)) == 8'h00));

  a_r9_pins_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr_en && addr == 4'd14)) |=> $stable(pins));

  a_r6_ch7_masked_pins: assert property (@(posedge clk) disable iff (!rst_n)
    hit[7] |=> ((pins & $past(msk7)) == ($past(dat7) & $past(msk7))));

  a_r10_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd14) |-> (rdata == '0));
endmodule

// File: tb/oc_unit_tb.sv
module oc_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [15:0] cnt = '0, wdata = '0, rdata;
  logic [3:0]  addr = '0;
  logic [7:0]  pins, irq;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  oc_unit u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .wr_en(wr_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .pins(pins), .irq(irq));

  // {cnt, tick(8b), expected pins, expected flags}
  localparam logic [39:0] VEC [8] = '{
    {16'd10, 8'd1, 8'h01, 8'h01},
    {16'd10, 8'd0, 8'h01, 8'h01},
    {16'd20, 8'd1, 8'h03, 8'h03},
    {16'd30, 8'd1, 8'h03, 8'h07},
    {16'd10, 8'd1, 8'h02, 8'h07},
    {16'd40, 8'd1, 8'h06, 8'h87},
    {16'd41, 8'd1, 8'h06, 8'h87},
    {16'd10, 8'd1, 8'h07, 8'h87}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 4'd0;
  endtask

  task automatic step(input logic [15:0] c, input logic t);
    @(negedge clk); cnt = c; tick = t;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic step_wr(input logic [15:0] c, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); cnt = c; tick = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0; addr = 4'd0;
  endtask

  task automatic flags_pins(input string req, input logic [7:0] ep, input logic [7:0] ef);
    logic [15:0] v;
    chk(req, {8'h00, pins}, {8'h00, ep});
    rd(4'd12, v);
    chk(req, v, {8'h00, ef});
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pins", {8'h00, pins}, 16'h0);
    chk("R1 irq", {8'h00, irq}, 16'h0);
    rd(4'd12, v); chk("R1 flags", v, 16'h0);
    rd(4'd0, v);  chk("R1 cmp0", v, 16'h0);

    wr(4'd0, 16'd10); wr(4'd1, 16'd20); wr(4'd2, 16'd30); wr(4'd7, 16'd40);
    wr(4'd8, 16'h0087);
    wr(4'd9, 16'h002D);
    wr(4'd11, 16'h040C);
    wr(4'd13, 16'h0001);

    // R2 R3 R4 R5 R8 vector walk
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][39:24], VEC[i][16]);
      flags_pins($sformatf("R2/R3/R4/R5 vec%0d", i), VEC[i][15:8], VEC[i][7:0]);
      chk($sformatf("R8 vec%0d irq", i), {8'h00, irq}, {8'h00, VEC[i][7:0] & 8'h01});
    end

    // R7 write-one-to-clear
    wr(4'd12, 16'h0081);
    flags_pins("R7 clear", 8'h07, 8'h06);
    chk("R8 irq cleared", {8'h00, irq}, 16'h0);
    step(16'd10, 1'b1);
    flags_pins("R4 toggle", 8'h06, 8'h07);
    chk("R8 irq set", {8'h00, irq}, 16'h0001);
    // R7 set wins over clear
    step_wr(16'd10, 4'd12, 16'h0001);
    flags_pins("R7 set wins", 8'h07, 8'h07);

    // R9 force
    wr(4'd12, 16'h00FF);
    wr(4'd14, 16'h0001);
    flags_pins("R9 force no flag", 8'h06, 8'h00);
    step_wr(16'd10, 4'd14, 16'h0001);
    flags_pins("R9 force with match", 8'h07, 8'h00);
    wr(4'd14, 16'h0004);
    flags_pins("R9 force ch2 low", 8'h03, 8'h00);
    wr(4'd14, 16'h0080);
    flags_pins("R5 force ch7", 8'h07, 8'h00);

    // R6 ch7 priority
    wr(4'd11, 16'h0002);
    wr(4'd7, 16'd20);
    step(16'd20, 1'b1);
    flags_pins("R6 ch7 priority", 8'h05, 8'h82);

    // R2 disabled channel
    wr(4'd3, 16'd50);
    wr(4'd9, 16'h00ED);
    step(16'd50, 1'b1);
    flags_pins("R2 disabled match", 8'h05, 8'h82);
    wr(4'd14, 16'h0008);
    flags_pins("R2 disabled force", 8'h05, 8'h82);

    // R10 R11 readback
    rd(4'd14, v); chk("R10 force reads 0", v, 16'h0);
    rd(4'd9, v);  chk("R11 act", v, 16'h00ED);
    rd(4'd11, v); chk("R11 ch7 mask/data", v, 16'h0002);
    rd(4'd15, v); chk("R11 pins", v, 16'h0005);
    rd(4'd0, v);  chk("R11 cmp0", v, 16'd10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule